// File: doc/BRIEF.md
# Elapsed-Time Clock with Alarm and Interval Timer

This block is a timekeeping unit that runs from a slow, synchronous tick enable. The tick is one clock-wide pulse at 32.768 kHz. The block holds a free-running 48-bit elapsed counter that software reads and writes as three 16-bit words. Whole seconds begin at bit 15 of the lowest word. A 48-bit alarm compare value uses the same alignment. When the counter advances onto the compare value, the alarm event is flagged.

Beside the counter runs a 32-bit interval timer. It counts down once per tick and reloads itself from a reload value. Each reload raises a periodic event. Both events collect in a shared status word, and software clears a bit by writing 1 to it. A control word holds one enable bit per event. Each enable gates its own interrupt output.

Word reads go straight to the live registers; nothing is latched. Software that needs a coherent 48-bit value reads all three words twice and keeps the result only when both passes agree.

Top module: `etick_rtc`

## Requirements
- R1: After synchronous reset, every counter, compare, reload, control and status register reads zero, and both interrupt outputs are low.
- R2: The elapsed counter (words at byte offsets 0x00 low, 0x02 middle, 0x04 high) increases by exactly one on each cycle with `tick` high and holds otherwise. It wraps from all ones to zero. Read data appears on `rdata` in the cycle after `rd_en`.
- R3: A write to one elapsed-counter word replaces only that word on the next edge; the other words keep their value. A seconds value S written as low = S[0]<<15, middle = S[16:1], high = S[32:17] reads back in the same form.
- R4: The alarm compare value sits at offsets 0x08, 0x0a and 0x0c (low to high). Status bit 0 becomes set in the cycle after the tick that carries the counter onto the compare value.
- R5: The interval reload value is written at 0x10 (low half) and 0x12 (high half). Writing either half loads the down-counter with the new reload value. The count reads at 0x14 and 0x16. Each tick decrements the count. A tick with the count at 1 reloads it instead and sets status bit 1, so events come every reload-value ticks.
- R6: With a reload value of zero, the count does not move on ticks and status bit 1 is never set.
- R7: The status word at 0x1e has bit 0 for the alarm and bit 1 for the interval timer; bits 15:2 read zero. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R8: If an event and a write-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R9: The control word at 0x1a has bit 0 as the alarm enable and bit 1 as the interval enable. `irq_alarm` equals status bit 0 AND enable bit 0, and `irq_period` equals status bit 1 AND enable bit 1, in the same cycle as the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 32.768 kHz count enable, one clock wide |
| addr | input | 5 | Byte offset of the addressed 16-bit word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_period | output | 1 | Interval timer interrupt |

## Verification
The bench drives the counter from all ones into the wrap. A carry that stops at a word boundary would leave a nonzero upper word. It writes a single counter word between ticks, where an implementation that reloads the whole counter would disturb its neighbours. It also moves the alarm one tick at a time up to the compare value; an off-by-one compare would flag one tick early or late.

For the interval timer, it checks that events come exactly every reload-value ticks. It checks that a zero reload freezes the count, which would otherwise underflow. Finally, it clears a status bit in the same cycle as a new event. A design where the clear wins would drop that event.

// File: rtl/etick_pkg.sv
package etick_pkg;
  localparam int unsigned AW = 5;
  localparam logic [AW-1:0] OFS_ELAPSED = 5'h00;
  localparam logic [AW-1:0] OFS_ALARM   = 5'h08;
  localparam logic [AW-1:0] OFS_RELOAD  = 5'h10;
  localparam logic [AW-1:0] OFS_COUNT   = 5'h14;
  localparam logic [AW-1:0] OFS_CTRL    = 5'h1a;
  localparam logic [AW-1:0] OFS_STATUS  = 5'h1e;
  localparam int unsigned ST_ALARM  = 0;
  localparam int unsigned ST_PERIOD = 1;
  localparam int unsigned NUM_SRC   = 2;
endpackage

// File: rtl/etick_wreg.sv
module etick_wreg #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   wr_word,
  input  logic [W-1:0]   wdata,
  output logic [W*N-1:0] q,
  output logic [W*N-1:0] q_nxt
);
  for (genvar k = 0; k < N; k++) begin : g_word
    assign q_nxt[k*W +: W] = wr_word[k] ? wdata : q[k*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/etick_elapsed.sv
module etick_elapsed #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [N-1:0]   wr_word,
  input  logic [W-1:0]   wdata,
  output logic [W*N-1:0] cnt
);
  localparam int unsigned CW = W * N;
  logic [CW-1:0] inc;
  logic [CW-1:0] nxt;

  assign inc = cnt + CW'(tick);

  for (genvar k = 0; k < N; k++) begin : g_word
    assign nxt[k*W +: W] = wr_word[k] ? wdata : inc[k*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end
endmodule

// File: rtl/etick_interval.sv
module etick_interval #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] rld_nxt,
  input  logic [W-1:0] rld,
  output logic [W-1:0] cnt,
  output logic         evt
);
  assign evt = tick && !load && (rld != '0) && (cnt <= W'(1));

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (load)                 cnt <= rld_nxt;
    else if (tick && rld != '0)    cnt <= evt ? rld : cnt - W'(1);
  end
endmodule

// File: rtl/etick_rtc.sv
module etick_rtc
  import etick_pkg::*;
#(
  parameter int unsigned WORD_W        = 16,
  parameter int unsigned ELAPSED_WORDS = 3,
  parameter int unsigned PERIOD_WORDS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq_alarm,
  output logic              irq_period
);
  localparam int unsigned EL_W = WORD_W * ELAPSED_WORDS;
  localparam int unsigned PR_W = WORD_W * PERIOD_WORDS;

  logic [ELAPSED_WORDS-1:0] wr_el, wr_cmp;
  logic [PERIOD_WORDS-1:0]  wr_rld;
  logic [EL_W-1:0]          cnt_q, cmp_q, cmp_nxt;
  logic [PR_W-1:0]          rld_q, rld_nxt, pcnt_q;
  logic                     al_evt, pr_evt;
  logic [NUM_SRC-1:0]       st_q, st_n, en_q, en_n, clr;
  logic [WORD_W-1:0]        rd_mux;

  always_comb begin
    for (int k = 0; k < ELAPSED_WORDS; k++) begin
      wr_el[k]  = wr_en && (addr == OFS_ELAPSED + AW'(2*k));
      wr_cmp[k] = wr_en && (addr == OFS_ALARM + AW'(2*k));
    end
    for (int k = 0; k < PERIOD_WORDS; k++)
      wr_rld[k] = wr_en && (addr == OFS_RELOAD + AW'(2*k));
  end

  etick_elapsed #(.W(WORD_W), .N(ELAPSED_WORDS)) i_elapsed (
    .clk(clk), .rst(rst), .tick(tick), .wr_word(wr_el), .wdata(wdata), .cnt(cnt_q));

  etick_wreg #(.W(WORD_W), .N(ELAPSED_WORDS)) i_cmp (
    .clk(clk), .rst(rst), .wr_word(wr_cmp), .wdata(wdata), .q(cmp_q), .q_nxt(cmp_nxt));

  etick_wreg #(.W(WORD_W), .N(PERIOD_WORDS)) i_rld (
    .clk(clk), .rst(rst), .wr_word(wr_rld), .wdata(wdata), .q(rld_q), .q_nxt(rld_nxt));

  etick_interval #(.W(PR_W)) i_interval (
    .clk(clk), .rst(rst), .tick(tick), .load(|wr_rld), .rld_nxt(rld_nxt),
    .rld(rld_q), .cnt(pcnt_q), .evt(pr_evt));

  // Alarm fires when the tick moves the counter onto the compare value
  assign al_evt = tick && ((cnt_q + EL_W'(1)) == cmp_q);

  always_comb begin
    clr = (wr_en && addr == OFS_STATUS) ? wdata[NUM_SRC-1:0] : '0;
    st_n = st_q & ~clr;
    st_n[ST_ALARM]  = st_n[ST_ALARM]  | al_evt;
    st_n[ST_PERIOD] = st_n[ST_PERIOD] | pr_evt;
    en_n = (wr_en && addr == OFS_CTRL) ? wdata[NUM_SRC-1:0] : en_q;
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < ELAPSED_WORDS; k++) begin
      if (addr == OFS_ELAPSED + AW'(2*k)) rd_mux = cnt_q[k*WORD_W +: WORD_W];
      if (addr == OFS_ALARM + AW'(2*k))   rd_mux = cmp_q[k*WORD_W +: WORD_W];
    end
    for (int k = 0; k < PERIOD_WORDS; k++) begin
      if (addr == OFS_RELOAD + AW'(2*k)) rd_mux = rld_q[k*WORD_W +: WORD_W];
      if (addr == OFS_COUNT + AW'(2*k))  rd_mux = pcnt_q[k*WORD_W +: WORD_W];
    end
    if (addr == OFS_CTRL)   rd_mux = WORD_W'(en_q);
    if (addr == OFS_STATUS) rd_mux = WORD_W'(st_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= '0;
      en_q       <= '0;
      irq_alarm  <= 1'b0;
      irq_period <= 1'b0;
      rdata      <= '0;
    end else begin
      st_q       <= st_n;
      en_q       <= en_n;
      irq_alarm  <= st_n[ST_ALARM] & en_n[ST_ALARM];
      irq_period <= st_n[ST_PERIOD] & en_n[ST_PERIOD];
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/etick_rtc_chk.sv
module etick_rtc_chk
  import etick_pkg::*;
#(
  parameter int unsigned WORD_W        = 16,
  parameter int unsigned ELAPSED_WORDS = 3,
  parameter int unsigned PERIOD_WORDS  = 2
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             tick,
  input logic                             wr_en,
  input logic [AW-1:0]                    addr,
  input logic [WORD_W-1:0]                wdata,
  input logic [WORD_W*ELAPSED_WORDS-1:0]  cnt_q,
  input logic [WORD_W*ELAPSED_WORDS-1:0]  cmp_q,
  input logic [WORD_W*PERIOD_WORDS-1:0]   rld_q,
  input logic [WORD_W*PERIOD_WORDS-1:0]   pcnt_q,
  input logic [NUM_SRC-1:0]               st_q,
  input logic [NUM_SRC-1:0]               en_q,
  input logic                             irq_alarm,
  input logic                             irq_period
);
  localparam int unsigned EL_W = WORD_W * ELAPSED_WORDS;
  localparam int unsigned PR_W = WORD_W * PERIOD_WORDS;

  logic wr_el_any, wr_rld_any, hit;
  always_comb begin
    wr_el_any  = 1'b0;
    wr_rld_any = 1'b0;
    for (int k = 0; k < ELAPSED_WORDS; k++)
      if (wr_en && addr == OFS_ELAPSED + AW'(2*k)) wr_el_any = 1'b1;
    for (int k = 0; k < PERIOD_WORDS; k++)
      if (wr_en && addr == OFS_RELOAD + AW'(2*k)) wr_rld_any = 1'b1;
    hit = tick && ((cnt_q + EL_W'(1)) == cmp_q);
  end

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_el_any) |=> $stable(cnt_q));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_el_any) |=> (cnt_q == $past(cnt_q) + EL_W'(1)));
  assert_alarm_hit_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> st_q[ST_ALARM]);
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (rld_q != '0) |-> (pcnt_q <= rld_q));
  assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (rld_q == PR_W'(0) && !wr_rld_any) |=> $stable(pcnt_q));
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_STATUS && wdata[ST_ALARM] && !hit) |=> !st_q[ST_ALARM]);
  assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_rld_any && rld_q != '0 && pcnt_q <= PR_W'(1)) |=> st_q[ST_PERIOD]);
  assert_irq_alarm_R9: assert property (@(posedge clk) disable iff (rst)
    irq_alarm == (st_q[ST_ALARM] && en_q[ST_ALARM]));
  assert_irq_period_R9: assert property (@(posedge clk) disable iff (rst)
    irq_period == (st_q[ST_PERIOD] && en_q[ST_PERIOD]));
endmodule

bind etick_rtc etick_rtc_chk #(
  .WORD_W(WORD_W), .ELAPSED_WORDS(ELAPSED_WORDS), .PERIOD_WORDS(PERIOD_WORDS)
) i_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt_q(cnt_q), .cmp_q(cmp_q), .rld_q(rld_q), .pcnt_q(pcnt_q),
  .st_q(st_q), .en_q(en_q), .irq_alarm(irq_alarm), .irq_period(irq_period));

// File: tb/test_etick_rtc.sv
module test_etick_rtc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_alarm, irq_period;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  etick_rtc i_etick_rtc (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_alarm(irq_alarm), .irq_period(irq_period));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic expect_rd(input string req, input logic [4:0] a, input logic [15:0] e);
    logic [15:0] d;
    bus_rd(a, d);
    check(req, d, e);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 32; a += 2) expect_rd("R1 reset read", 5'(a), 16'h0);
    check("R1 irq_alarm", irq_alarm, 0);
    check("R1 irq_period", irq_period, 0);
  endtask

  task automatic t_count;
    ticks(5);
    expect_rd("R2 low after 5 ticks", 5'h00, 16'd5);
    expect_rd("R2 mid", 5'h02, 16'h0);
    expect_rd("R2 high", 5'h04, 16'h0);
    bus_wr(5'h00, 16'hFFFF); bus_wr(5'h02, 16'hFFFF); bus_wr(5'h04, 16'hFFFF);
    expect_rd("R2 all ones low", 5'h00, 16'hFFFF);
    ticks(1);
    expect_rd("R2 wrap low", 5'h00, 16'h0);
    expect_rd("R2 wrap mid", 5'h02, 16'h0);
    expect_rd("R2 wrap high", 5'h04, 16'h0);
  endtask

  task automatic t_seconds;
    logic [63:0] s;
    logic [15:0] lo, mi, hi;
    s = 64'h1_2345_6789;
    bus_wr(5'h00, 16'((s & 1) << 15));
    bus_wr(5'h02, 16'(s >> 1));
    bus_wr(5'h04, 16'(s >> 17));
    ticks(3);
    bus_rd(5'h00, lo); bus_rd(5'h02, mi); bus_rd(5'h04, hi);
    check("R3 low word", lo, 16'h8003);
    check("R3 seconds", {hi, mi, lo[15]}, s);
    bus_wr(5'h02, 16'h0000);
    expect_rd("R3 low kept", 5'h00, 16'h8003);
    expect_rd("R3 high kept", 5'h04, 16'(s >> 17));
    expect_rd("R3 mid replaced", 5'h02, 16'h0000);
  endtask

  task automatic t_alarm;
    bus_wr(5'h00, 0); bus_wr(5'h02, 0); bus_wr(5'h04, 0);
    bus_wr(5'h08, 16'd4); bus_wr(5'h0a, 0); bus_wr(5'h0c, 0);
    bus_wr(5'h1e, 16'h3);
    bus_wr(5'h1a, 16'h1);
    ticks(3);
    expect_rd("R4 no alarm before compare", 5'h1e, 16'h0);
    check("R9 irq_alarm low", irq_alarm, 0);
    ticks(1);
    check("R9 irq_alarm high", irq_alarm, 1);
    expect_rd("R4 alarm status", 5'h1e, 16'h1);
    bus_wr(5'h1e, 16'h0);
    expect_rd("R7 write 0 keeps bit", 5'h1e, 16'h1);
    bus_wr(5'h1a, 16'h0);
    check("R9 disabled irq low", irq_alarm, 0);
    bus_wr(5'h1e, 16'hFFFF);
    expect_rd("R7 cleared", 5'h1e, 16'h0);
  endtask

  task automatic t_period;
    bus_wr(5'h1a, 16'h3);
    bus_wr(5'h12, 16'h0); bus_wr(5'h10, 16'd3);
    expect_rd("R5 count loaded", 5'h14, 16'd3);
    ticks(2);
    expect_rd("R5 count after 2", 5'h14, 16'd1);
    expect_rd("R5 no event yet", 5'h1e, 16'h0);
    check("R9 irq_period low", irq_period, 0);
    ticks(1);
    check("R9 irq_period high", irq_period, 1);
    expect_rd("R5 event", 5'h1e, 16'h2);
    expect_rd("R5 reloaded", 5'h14, 16'd3);
    bus_wr(5'h1e, 16'h2);
    bus_wr(5'h10, 16'h0); bus_wr(5'h12, 16'h1);
    expect_rd("R5 count high", 5'h16, 16'h1);
    expect_rd("R5 count low", 5'h14, 16'h0);
    ticks(1);
    expect_rd("R5 borrow low", 5'h14, 16'hFFFF);
    expect_rd("R5 borrow high", 5'h16, 16'h0);
  endtask

  task automatic t_disabled;
    logic [15:0] d;
    bus_wr(5'h12, 16'h0);
    bus_wr(5'h1e, 16'h3);
    ticks(5);
    expect_rd("R6 count frozen", 5'h14, 16'h0);
    bus_rd(5'h1e, d);
    check("R6 no period event", d & 16'h2, 16'h0);
  endtask

  task automatic t_event_wins;
    logic [15:0] d;
    bus_wr(5'h10, 16'd1);
    bus_wr(5'h1e, 16'h3);
    expect_rd("R7 cleared before race", 5'h1e, 16'h0);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 5'h1e; wdata = 16'h2;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    bus_rd(5'h1e, d);
    check("R8 event beats clear", d & 16'h2, 16'h2);
    bus_wr(5'h1e, 16'h2);
    bus_rd(5'h1e, d);
    check("R7 clear without event", d & 16'h2, 16'h0);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_seconds();
    t_alarm();
    t_period();
    t_disabled();
    t_event_wins();
    summary();
    $finish;
  end
endmodule